// File: doc/BRIEF.md
# Enhanced Parallel Port Host Cycle Controller

This block sits between a simple host request bus and an 8-bit bidirectional parallel port that runs in enhanced (EPP-style) handshake mode. Each host request becomes one port cycle. An address cycle uses the address strobe and a data cycle uses the data strobe. The cycle moves a byte out to the peripheral or reads one in. The host's ready output stays low until the peripheral signals completion on its wait line, so the peripheral alone sets how long each host access lasts.

The block also holds a small control register and a status register. The control register holds an interrupt enable and the peripheral initialise request. The status register reports the peripheral's select, paper-error, fault and interrupt lines, plus a sticky timeout flag. A cycle counter aborts any strobe that the peripheral does not acknowledge within `TIMEOUT_CLKS` clocks. All peripheral status inputs and the wait line pass through two-flop synchronizers before use. The port data bus is split into input, output and output-enable, which a pad ring joins into one bidirectional bus.

Top module: `epp_host_ctrl`

## Requirements
- R1: `pp_write_n` is low for the whole of a write cycle and high for a read cycle, for both address and data cycles, and high while idle.
- R2: `host_rdy` is high only when idle. A `host_req` seen while `host_rdy` is high starts a cycle, and `host_rdy` is low from the next clock until that cycle ends.
- R3: A strobe stays asserted until the synchronized wait input is high. The strobe is then negated, and `host_rdy` does not return high until wait has gone low again.
- R4: A data cycle (`host_addr_sel`=0) asserts only `pp_dstrb_n`, and an address cycle (`host_addr_sel`=1) asserts only `pp_astrb_n`. The two strobes are never low together.
- R5: A read cycle that completes normally loads the byte on `pp_data_i` into `host_rdata`, which is valid once `host_rdy` is high again.
- R6: `pp_data_oe` is high only during write cycles. While it is high, `pp_data_o` carries the byte given with the request, and it is held steady for as long as the strobe is asserted.
- R7: `irq` is high exactly when control bit 4 is set and the synchronized `pp_intr_n` is low.
- R8: Reading the status register (`reg_addr`=1) returns the following, with all other bits zero:
  - bit 0: timeout flag
  - bit 3: `pp_fault_n` level
  - bit 4: `pp_select` level
  - bit 5: `pp_perror` level
  - bit 6: `pp_intr_n` level
- R9: Writing `reg_addr`=0 stores all 8 bits of the control register, and reading `reg_addr`=0 returns them. `pp_init_n` is the inverse of control bit 2.
- R10: Suppose the wait input stays low through `TIMEOUT_CLKS` clocks of strobe assertion. The cycle is then aborted, `host_rdy` is low for exactly `TIMEOUT_CLKS`+2 clocks in total, and status bit 0 is set. An aborted read returns 8'hFF. Writing the status register with bit 0 set clears the flag.
- R11: After reset, the outputs and registers take these values:
  - `host_rdy`=1, both strobes high, `pp_write_n`=1 and `pp_data_oe`=0
  - `irq`=0, `pp_init_n`=1 and `host_rdata`=0
  - the control register reads 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | One-clock request, taken when host_rdy is high |
| host_addr_sel | input | 1 | 1 = address cycle, 0 = data cycle |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_wdata | input | 8 | Byte to write |
| host_rdata | output | 8 | Byte read from the port |
| host_rdy | output | 1 | High when idle; low stretches the host access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Host interrupt request |
| pp_write_n | output | 1 | Port direction: low = write |
| pp_dstrb_n | output | 1 | Data strobe, active low |
| pp_astrb_n | output | 1 | Address strobe, active low |
| pp_init_n | output | 1 | Peripheral initialise, active low |
| pp_wait | input | 1 | Peripheral ready/complete, high = done |
| pp_intr_n | input | 1 | Peripheral interrupt, active low |
| pp_select | input | 1 | Peripheral on-line |
| pp_perror | input | 1 | Peripheral paper error |
| pp_fault_n | input | 1 | Peripheral fault line |
| pp_data_i | input | 8 | Port bus input |
| pp_data_o | output | 8 | Port bus output |
| pp_data_oe | output | 1 | Port bus output enable |

## Verification
The assertions assume that the host raises `host_req` for a single clock and only while `host_rdy` is high. They also assume that the peripheral never raises wait before a strobe is asserted, so a stale high wait cannot end the next cycle early. The bench acts as the peripheral inside its cycle task and follows both rules. It lowers wait as soon as it sees both strobes high. Between cycles it changes `pp_data_i` and the status lines only while no strobe is asserted. The timeout case is the one place where wait is deliberately held low.

// File: rtl/epp_pkg.sv
// Package: shared state encoding and register bit positions for the
// enhanced parallel port host cycle controller.
package epp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RELEASE = 2'd3
    } epp_state_t;

    // Control register bit positions
    localparam int CTL_INIT_BIT   = 2;
    localparam int CTL_IRQ_EN_BIT = 4;

    // Status register bit positions
    localparam int STA_TMO_BIT   = 0;
    localparam int STA_FAULT_BIT = 3;
    localparam int STA_SEL_BIT   = 4;
    localparam int STA_PERR_BIT  = 5;
    localparam int STA_INTR_BIT  = 6;
endpackage

// File: rtl/epp_sync.sv
// Module: epp_sync
// Two-flop synchronizer for a vector of independent asynchronous levels.
// Assumes each bit is a slow level; no bus coherency across bits.
module epp_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit, reset to the inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/epp_cycle_fsm.sv
// Module: epp_cycle_fsm
// Runs one port cycle per accepted host request: setup, strobe until wait
// high (or timeout), release until wait low. Assumes wait_s is synchronized.
module epp_cycle_fsm
    import epp_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       addr_sel,
    input  logic       rd,
    input  logic [7:0] wdata,
    input  logic       wait_s,
    input  logic [7:0] pdata_i,
    output logic       rdy,
    output logic       write_n,
    output logic       dstrb_n,
    output logic       astrb_n,
    output logic       data_oe,
    output logic [7:0] data_o,
    output logic [7:0] rdata,
    output logic       timeout_set
);
    localparam int             CW  = $clog2(TIMEOUT_CLKS + 1);
    localparam logic [CW-1:0]  LIM = CW'(TIMEOUT_CLKS - 1);

    epp_state_t    state, state_nx;
    logic          is_addr, is_rd;
    logic [7:0]    wbyte;
    logic [CW-1:0] cnt;
    logic          abort;

    assign abort = (state == ST_STROBE) && !wait_s && (cnt == LIM);

    // Next-state selection for the handshake sequence.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:    if (req) state_nx = ST_SETUP;
            ST_SETUP:   state_nx = ST_STROBE;
            ST_STROBE:  if (wait_s || abort) state_nx = ST_RELEASE;
            ST_RELEASE: if (!wait_s) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register, request latch, timeout counter and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            is_addr <= 1'b0;
            is_rd   <= 1'b1;
            wbyte   <= '0;
            cnt     <= '0;
            rdata   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req) begin
                is_addr <= addr_sel;
                is_rd   <= rd;
                wbyte   <= wdata;
            end
            if (state == ST_SETUP) cnt <= '0;
            else if (state == ST_STROBE && !wait_s && !abort) cnt <= cnt + 1'b1;
            if (state == ST_STROBE && is_rd) begin
                if (wait_s)     rdata <= pdata_i;
                else if (abort) rdata <= 8'hFF;
            end
        end
    end

    // Port side and host side outputs decoded from state.
    always_comb begin
        rdy         = (state == ST_IDLE);
        write_n     = (state == ST_IDLE) || is_rd;
        data_oe     = (state != ST_IDLE) && !is_rd;
        data_o      = wbyte;
        dstrb_n     = !((state == ST_STROBE) && !is_addr);
        astrb_n     = !((state == ST_STROBE) && is_addr);
        timeout_set = abort;
    end
endmodule

// File: rtl/epp_regs.sv
// Module: epp_regs
// Control and status registers, interrupt and init line generation.
// Assumes the peripheral status inputs are already synchronized.
module epp_regs
    import epp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       timeout_set,
    input  logic       sel_s,
    input  logic       perr_s,
    input  logic       fault_s,
    input  logic       intr_s,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       init_n
);
    logic [7:0] ctl;
    logic       tmo;
    logic [7:0] sta;

    // Control register write and sticky timeout flag (set wins over clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
            tmo <= 1'b0;
        end else begin
            if (reg_wr && !reg_addr) ctl <= reg_wdata;
            if (timeout_set) tmo <= 1'b1;
            else if (reg_wr && reg_addr && reg_wdata[STA_TMO_BIT]) tmo <= 1'b0;
        end
    end

    // Status word assembly and read mux.
    always_comb begin
        sta                = '0;
        sta[STA_TMO_BIT]   = tmo;
        sta[STA_FAULT_BIT] = fault_s;
        sta[STA_SEL_BIT]   = sel_s;
        sta[STA_PERR_BIT]  = perr_s;
        sta[STA_INTR_BIT]  = intr_s;
        reg_rdata          = reg_addr ? sta : ctl;
        irq                = ctl[CTL_IRQ_EN_BIT] && !intr_s;
        init_n             = !ctl[CTL_INIT_BIT];
    end
endmodule

// File: rtl/epp_host_ctrl.sv
// Module: epp_host_ctrl
// Top: host request bus to enhanced parallel port cycles, with control and
// status registers. Assumes host_req is a single-clock pulse while host_rdy.
module epp_host_ctrl #(
    parameter int TIMEOUT_CLKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_req,
    input  logic       host_addr_sel,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       host_rdy,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       pp_write_n,
    output logic       pp_dstrb_n,
    output logic       pp_astrb_n,
    output logic       pp_init_n,
    input  logic       pp_wait,
    input  logic       pp_intr_n,
    input  logic       pp_select,
    input  logic       pp_perror,
    input  logic       pp_fault_n,
    input  logic [7:0] pp_data_i,
    output logic [7:0] pp_data_o,
    output logic       pp_data_oe
);
    logic [4:0] async_in, sync_out;
    logic       timeout_set;

    assign async_in = {pp_wait, pp_intr_n, pp_select, pp_perror, pp_fault_n};

    epp_sync #(.W(5), .RST_VAL(5'b01001)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out)
    );

    epp_cycle_fsm #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req(host_req), .addr_sel(host_addr_sel), .rd(host_rd),
        .wdata(host_wdata), .wait_s(sync_out[4]), .pdata_i(pp_data_i),
        .rdy(host_rdy), .write_n(pp_write_n), .dstrb_n(pp_dstrb_n),
        .astrb_n(pp_astrb_n), .data_oe(pp_data_oe), .data_o(pp_data_o),
        .rdata(host_rdata), .timeout_set(timeout_set)
    );

    epp_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .timeout_set(timeout_set),
        .sel_s(sync_out[2]), .perr_s(sync_out[1]), .fault_s(sync_out[0]),
        .intr_s(sync_out[3]),
        .reg_rdata(reg_rdata), .irq(irq), .init_n(pp_init_n)
    );
endmodule

// File: rtl/epp_host_ctrl_chk.sv
// Module: epp_host_ctrl_chk
// Port-level protocol checks for epp_host_ctrl, attached with bind.
// Assumes the host pulses host_req only while host_rdy is high.
module epp_host_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_req,
    input logic       host_rdy,
    input logic       pp_write_n,
    input logic       pp_dstrb_n,
    input logic       pp_astrb_n,
    input logic       pp_data_oe,
    input logic [7:0] pp_data_o
);
    logic strb;
    assign strb = !pp_dstrb_n || !pp_astrb_n;

    // R4: never both strobes
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pp_dstrb_n && !pp_astrb_n));

    // R6: output enable only for writes
    assert_oe_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pp_data_oe |-> !pp_write_n);

    // R6: write data steady under strobe
    assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && pp_data_oe && $past(strb) && $past(rst_n)) |-> $stable(pp_data_o));

    // R1: direction steady under strobe
    assert_dir_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && $past(strb) && $past(rst_n)) |-> $stable(pp_write_n));

    // R2: a strobe implies the host is held
    assert_rdy_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> !host_rdy);

    // R2: accepted request drops ready next clock
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_rdy) |=> !host_rdy);
endmodule

bind epp_host_ctrl epp_host_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_rdy(host_rdy),
    .pp_write_n(pp_write_n), .pp_dstrb_n(pp_dstrb_n), .pp_astrb_n(pp_astrb_n),
    .pp_data_oe(pp_data_oe), .pp_data_o(pp_data_o)
);

// File: tb/test_epp_host_ctrl.sv
// Bench: sweeps every byte over address/data and read/write cycles with the
// bench acting as peripheral, then registers, interrupt, init and timeout.
module test_epp_host_ctrl;
    localparam int TMO = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req = 1'b0, host_addr_sel = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rdy;
    logic       reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       pp_write_n, pp_dstrb_n, pp_astrb_n, pp_init_n;
    logic       pp_wait = 1'b0, pp_intr_n = 1'b1, pp_select = 1'b0;
    logic       pp_perror = 1'b0, pp_fault_n = 1'b1;
    logic [7:0] pp_data_i = '0;
    logic [7:0] pp_data_o;
    logic       pp_data_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    epp_host_ctrl #(.TIMEOUT_CLKS(TMO)) i_epp_host_ctrl (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    // One host cycle; the bench plays the peripheral at each falling edge.
    task automatic port_cycle(input logic sel, input logic rd, input logic [7:0] v,
                              input int dly, input logic [7:0] resp);
        bit seen = 0, wait_done = 0, dir_ok = 1, both = 0;
        bit got_a = 0, oe_seen = 0;
        logic [7:0] dat = '0;
        int d = dly;
        pp_data_i = resp;
        @(negedge clk);
        host_req = 1'b1; host_addr_sel = sel; host_rd = rd; host_wdata = v;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            host_req = 1'b0;
            if (host_rdy) break;
            if (pp_write_n !== rd) dir_ok = 0;
            if (!pp_dstrb_n || !pp_astrb_n) begin
                if (!pp_dstrb_n && !pp_astrb_n) both = 1;
                if (!seen) begin
                    seen = 1; got_a = !pp_astrb_n; oe_seen = pp_data_oe; dat = pp_data_o;
                end
                if (!pp_wait) begin
                    if (d == 0) begin pp_wait = 1'b1; wait_done = 1; end
                    else d--;
                end
            end else if (pp_wait) begin
                pp_wait = 1'b0;
            end
        end
        chk(host_rdy && pp_wait == 1'b0 && wait_done, "R3", {host_rdy, wait_done}, 3);
        chk(dir_ok, "R1", pp_write_n, rd);
        chk(!both && got_a == sel, "R4", got_a, sel);
        if (rd) begin
            chk(!oe_seen, "R6", oe_seen, 0);
            chk(host_rdata == resp, "R5", host_rdata, resp);
        end else begin
            chk(oe_seen && dat == v, "R6", dat, v);
        end
        chk(host_rdy && pp_write_n && pp_dstrb_n && pp_astrb_n && !pp_data_oe,
            "R2", {pp_write_n, pp_dstrb_n, pp_astrb_n, pp_data_oe}, 4'hE);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        int lowcnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(host_rdy && pp_dstrb_n && pp_astrb_n && pp_write_n && !pp_data_oe,
            "R11", {host_rdy, pp_dstrb_n, pp_astrb_n, pp_write_n, pp_data_oe}, 5'h1E);
        chk(!irq && pp_init_n && host_rdata == 0, "R11", host_rdata, 0);
        reg_read(1'b0, r);
        chk(r == 8'h00, "R11", r, 0);

        // R1 R4 R5 R6: sweep every byte, both cycle kinds, both directions
        for (int v = 0; v < 256; v++) begin
            for (int s = 0; s < 2; s++) begin
                port_cycle(s[0], 1'b0, v[7:0], (v + s) % 4, 8'h00);
                port_cycle(s[0], 1'b1, 8'h00, (v + 2 * s) % 5,
                           ~v[7:0] ^ (s[0] ? 8'h5A : 8'h00));
            end
        end

        // R9: control readback and init line
        reg_write(1'b0, 8'h04);
        reg_read(1'b0, r);
        chk(r == 8'h04 && !pp_init_n, "R9", {r, pp_init_n}, 9'h008);
        reg_write(1'b0, 8'hEB);
        reg_read(1'b0, r);
        chk(r == 8'hEB && pp_init_n, "R9", {r, pp_init_n}, 9'h1D7);

        // R7: interrupt enable and line combinations
        for (int k = 0; k < 4; k++) begin
            reg_write(1'b0, k[0] ? 8'h10 : 8'h00);
            pp_intr_n = k[1];
            repeat (4) @(negedge clk);
            chk(irq == (k[0] && !k[1]), "R7", irq, k[0] && !k[1]);
        end
        pp_intr_n = 1'b1;

        // R8: status lines, all sixteen combinations
        for (int k = 0; k < 16; k++) begin
            pp_fault_n = k[0]; pp_select = k[1]; pp_perror = k[2]; pp_intr_n = k[3];
            repeat (4) @(negedge clk);
            reg_read(1'b1, r);
            chk(r == {1'b0, k[3], k[2], k[1], k[0], 3'b000}, "R8", r,
                {1'b0, k[3], k[2], k[1], k[0], 3'b000});
        end
        pp_intr_n = 1'b1; pp_fault_n = 1'b1;

        // R10: timeout on a read with wait stuck low
        pp_wait = 1'b0;
        @(negedge clk);
        host_req = 1'b1; host_addr_sel = 1'b0; host_rd = 1'b1;
        lowcnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            host_req = 1'b0;
            if (host_rdy) break;
            lowcnt++;
        end
        chk(lowcnt == TMO + 2, "R10", lowcnt, TMO + 2);
        chk(host_rdata == 8'hFF, "R10", host_rdata, 8'hFF);
        reg_read(1'b1, r);
        chk(r[0] == 1'b1, "R10", r[0], 1);
        reg_write(1'b1, 8'h01);
        reg_read(1'b1, r);
        chk(r[0] == 1'b0, "R10", r[0], 0);

        // R10: timeout on a write also flags; then a normal cycle still works
        @(negedge clk);
        host_req = 1'b1; host_rd = 1'b0; host_wdata = 8'h3C;
        lowcnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            host_req = 1'b0;
            if (host_rdy) break;
            lowcnt++;
        end
        chk(lowcnt == TMO + 2, "R10", lowcnt, TMO + 2);
        reg_read(1'b1, r);
        chk(r[0] == 1'b1, "R10", r[0], 1);
        port_cycle(1'b1, 1'b1, 8'h00, 3, 8'hC3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule